// File: doc/BRIEF.md
# Slave-Controlled Up/Down Counter

This block is a counter core whose stepping is chosen by a 3-bit slave mode field. In the free-running mode it advances on a prescaler tick while software enables it. Three quadrature modes turn two already-filtered timer inputs into up and down steps. Four trigger modes let an external trigger line restart the count, gate it, start it, or clock it directly. A polarity bit picks the active level of the trigger line.

The counter runs from zero up to an active reload value and back to zero. Counting down, it runs from zero back to the reload value. Each wrap raises a one-cycle update pulse. The reload input is a preload: it is copied into the active reload register only on an update event, whether that event comes from a wrap, a software request or a trigger restart. The direction flag shows the sense of the last step. A trigger pulse marks every active trigger edge while one of the trigger modes is selected.

Every edge on an input is found by comparing the sample with a registered copy of the previous sample. All outputs are registered and change on the clock edge that samples the stimulus.

Top module: `slave_mode_counter`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, count is 0, dir_down is 0, and update_pulse and trig_pulse are 0. The active reload register resets to all ones.
- R2: In mode 0 the counter steps up by one on each cycle that has both cnt_en and presc_tick high. It holds when either is low.
- R3: An up step taken from count == active reload gives 0. A down step taken from 0 gives reload_val. Either wrap pulses update_pulse for one cycle.
- R4: reload_val takes effect only on an update event. sw_update high sets count to 0, pulses update_pulse and loads the active reload, in every mode. This has priority over any step.
- R5: In mode 1, with cnt_en high, each change of ti_a is one step. The step is up when the new ti_a differs from ti_b and down otherwise. Changes of ti_b alone do not count.
- R6: In mode 2, with cnt_en high, each change of ti_b is one step. The step is up when the new ti_b equals ti_a and down otherwise. Changes of ti_a alone do not count.
- R7: In mode 3, a change of only one input steps as in R5 or R6. A cycle in which both inputs change gives no step. No encoder mode counts while cnt_en is low.
- R8: dir_down takes the sense of every step (1 = down). Steps outside the encoder modes are always up. Cycles without a step leave dir_down unchanged.
- R9: In mode 4 the counter steps as in mode 0. An active trigger edge sets count to 0, pulses update_pulse and loads the active reload.
- R10: In mode 5 the counter steps as in mode 0, but only while the trigger is at its active level. While the trigger is inactive it holds its value and is not cleared.
- R11: In mode 6 an active trigger edge starts the counter. Ticks are counted from the next cycle on, even with cnt_en low, until the mode changes. Trigger edges never stop the counter.
- R12: In mode 7, with cnt_en high, each active trigger edge steps the counter up by one. presc_tick is ignored.
- R13: The trigger is active high when trig_pol is 0 and active low when trig_pol is 1. trig_pulse is high for one cycle after each active edge in modes 4 to 7, and never in modes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Slave mode (0 free, 1-3 encoder, 4 restart, 5 gated, 6 start, 7 trigger clock) |
| trig_pol | input | 1 | 1 inverts the trigger line |
| ti_a | input | 1 | Filtered timer input A |
| ti_b | input | 1 | Filtered timer input B |
| trig_in | input | 1 | Selected trigger line |
| cnt_en | input | 1 | Counter enable |
| presc_tick | input | 1 | Prescaler output tick |
| reload_val | input | 16 | Preload value for the active reload |
| sw_update | input | 1 | Software update request |
| count | output | 16 | Counter value |
| dir_down | output | 1 | Sense of the last step, 1 = down |
| update_pulse | output | 1 | One-cycle update event |
| trig_pulse | output | 1 | One-cycle trigger event |

## Verification
The encoder modes are driven with forward and backward quadrature sequences. Edges on the input that a single-channel mode does not count show that this mode ignores them. In mode 3, a cycle with a change on both inputs at once shows that it gives no step, while single changes still step. The count is walked through zero and through the reload value in both senses, so the two wrap targets can be told apart. The trigger line is held at a level and toggled in each trigger mode, once with inverted polarity, which separates level action (gating) from edge action (restart, start, clocking). A directed sequence changes the preload and shows that the wrap point moves only after an update event.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    typedef enum logic [2:0] {
        SM_FREE    = 3'd0,
        SM_ENC_A   = 3'd1,
        SM_ENC_B   = 3'd2,
        SM_ENC_AB  = 3'd3,
        SM_RESTART = 3'd4,
        SM_GATED   = 3'd5,
        SM_START   = 3'd6,
        SM_TRGCLK  = 3'd7
    } slave_mode_e;

    typedef struct packed {
        logic step;
        logic down;
    } step_t;

    localparam int unsigned EDGE_A   = 0;
    localparam int unsigned EDGE_B   = 1;
    localparam int unsigned EDGE_TRG = 2;
    localparam int unsigned EDGE_N   = 3;

endpackage

// File: rtl/tsm_edge_detect.sv
module tsm_edge_detect #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    output logic [W-1:0] chg
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < int'(W); i++) begin : g_bit
        assign chg[i] = smp[i] ^ prev_q[i];
    end
endmodule

// File: rtl/tsm_quad_decode.sv
module tsm_quad_decode
    import tsm_pkg::*;
(
    input  slave_mode_e mode,
    input  logic        cnt_en,
    input  logic        a_lvl,
    input  logic        b_lvl,
    input  logic        a_chg,
    input  logic        b_chg,
    output step_t       stp
);
    step_t a_step, b_step;

    always_comb begin
        // A leads B in the up sense: A moves to differ from B
        a_step.step = a_chg;
        a_step.down = ~(a_lvl ^ b_lvl);
        // B moves to match A in the up sense
        b_step.step = b_chg;
        b_step.down = a_lvl ^ b_lvl;

        stp = '0;
        unique case (mode)
            SM_ENC_A:  stp = a_step;
            SM_ENC_B:  stp = b_step;
            SM_ENC_AB: begin
                if (a_chg && !b_chg)      stp = a_step;
                else if (b_chg && !a_chg) stp = b_step;
                else                      stp = '0;
            end
            default:   stp = '0;
        endcase
        if (!cnt_en) stp = '0;
    end
endmodule

// File: rtl/tsm_trig_ctrl.sv
module tsm_trig_ctrl
    import tsm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  slave_mode_e mode,
    input  logic        trg_lvl,
    input  logic        trg_rise,
    input  logic        cnt_en,
    input  logic        tick,
    output logic        step_up,
    output logic        restart,
    output logic        trig_evt
);
    logic run_d, run_q;
    logic en_eff;

    always_comb begin
        run_d = run_q;
        if (mode != SM_START) run_d = 1'b0;
        else if (trg_rise)    run_d = 1'b1;

        en_eff   = cnt_en | run_q;
        step_up  = 1'b0;
        restart  = 1'b0;
        trig_evt = mode[2] & trg_rise;

        unique case (mode)
            SM_FREE:    step_up = cnt_en & tick;
            SM_RESTART: begin
                step_up = cnt_en & tick;
                restart = trg_rise;
            end
            SM_GATED:   step_up = cnt_en & tick & trg_lvl;
            SM_START:   step_up = en_eff & tick;
            SM_TRGCLK:  step_up = cnt_en & trg_rise;
            default:    step_up = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/slave_mode_counter.sv
module slave_mode_counter
    import tsm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_sel,
    input  logic             trig_pol,
    input  logic             ti_a,
    input  logic             ti_b,
    input  logic             trig_in,
    input  logic             cnt_en,
    input  logic             presc_tick,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             sw_update,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             update_pulse,
    output logic             trig_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] arr;
        logic             dir;
        logic             upd;
        logic             trg;
    } state_t;

    slave_mode_e       mode;
    logic              trg_lvl;
    logic [EDGE_N-1:0] smp, chg;
    step_t             enc;
    logic              tc_step, tc_restart, tc_trig;
    state_t            st_d, st_q;

    assign mode    = slave_mode_e'(mode_sel);
    assign trg_lvl = trig_in ^ trig_pol;

    always_comb begin
        smp           = '0;
        smp[EDGE_A]   = ti_a;
        smp[EDGE_B]   = ti_b;
        smp[EDGE_TRG] = trg_lvl;
    end

    tsm_edge_detect #(.W(EDGE_N)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .smp   (smp),
        .chg   (chg)
    );

    tsm_quad_decode i_quad (
        .mode   (mode),
        .cnt_en (cnt_en),
        .a_lvl  (ti_a),
        .b_lvl  (ti_b),
        .a_chg  (chg[EDGE_A]),
        .b_chg  (chg[EDGE_B]),
        .stp    (enc)
    );

    tsm_trig_ctrl i_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .trg_lvl  (trg_lvl),
        .trg_rise (chg[EDGE_TRG] & trg_lvl),
        .cnt_en   (cnt_en),
        .tick     (presc_tick),
        .step_up  (tc_step),
        .restart  (tc_restart),
        .trig_evt (tc_trig)
    );

    always_comb begin
        logic do_step, go_down;
        st_d     = st_q;
        st_d.upd = 1'b0;
        st_d.trg = tc_trig;
        do_step  = enc.step | tc_step;
        go_down  = enc.step & enc.down;

        if (sw_update || tc_restart) begin
            st_d.cnt = '0;
            st_d.upd = 1'b1;
            st_d.arr = reload_val;
        end else if (do_step) begin
            st_d.dir = go_down;
            if (!go_down) begin
                if (st_q.cnt == st_q.arr) begin
                    st_d.cnt = '0;
                    st_d.upd = 1'b1;
                    st_d.arr = reload_val;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.cnt = reload_val;
                    st_d.upd = 1'b1;
                    st_d.arr = reload_val;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.arr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count        = st_q.cnt;
    assign dir_down     = st_q.dir;
    assign update_pulse = st_q.upd;
    assign trig_pulse   = st_q.trg;
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_sel,
    input logic             trig_pol,
    input logic             trig_in,
    input logic             cnt_en,
    input logic             sw_update,
    input logic [CNT_W-1:0] count,
    input logic             dir_down,
    input logic             update_pulse,
    input logic             trig_pulse
);
    // R3, R4: an update event seen while counting up always leaves zero
    assert_update_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (update_pulse && !dir_down) |-> (count == '0));

    // R2: free mode with enable low holds the count
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd0 && !cnt_en && !sw_update) |=> $stable(count));

    // R10: gated mode with inactive trigger holds the count
    assert_gate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd5 && !(trig_in ^ trig_pol) && !sw_update) |=> $stable(count));

    // R13: no trigger event outside the trigger modes
    assert_no_trig_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel[2]) |=> !trig_pulse);

    // R8: outside the encoder modes the direction never turns to down
    assert_up_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[2] || mode_sel == 3'd0) |=> (!dir_down || $stable(dir_down)));
endmodule

bind slave_mode_counter tsm_checker #(.CNT_W(CNT_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .trig_pol     (trig_pol),
    .trig_in      (trig_in),
    .cnt_en       (cnt_en),
    .sw_update    (sw_update),
    .count        (count),
    .dir_down     (dir_down),
    .update_pulse (update_pulse),
    .trig_pulse   (trig_pulse)
);

// File: tb/test_slave_mode_counter.sv
`timescale 1ns/1ps
module test_slave_mode_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = '0;
    logic        trig_pol = 1'b0, ti_a = 1'b0, ti_b = 1'b0, trig_in = 1'b0;
    logic        cnt_en = 1'b0, presc_tick = 1'b0, sw_update = 1'b0;
    logic [15:0] reload_val = '0;
    logic [15:0] count;
    logic        dir_down, update_pulse, trig_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    slave_mode_counter i_slave_mode_counter (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .trig_pol(trig_pol),
        .ti_a(ti_a), .ti_b(ti_b), .trig_in(trig_in), .cnt_en(cnt_en),
        .presc_tick(presc_tick), .reload_val(reload_val), .sw_update(sw_update),
        .count(count), .dir_down(dir_down), .update_pulse(update_pulse),
        .trig_pulse(trig_pulse)
    );

    // {mode, pol a b trig en tick swu, reload, count, dir upd trg}
    localparam int NV = 56;
    localparam logic [44:0] VEC [NV] = '{
        {3'd0, 7'b0_00_0_1_0_1, 16'd5, 16'd0, 3'b010},
        {3'd0, 7'b0_00_0_1_1_0, 16'd5, 16'd1, 3'b000},
        {3'd0, 7'b0_00_0_1_1_0, 16'd5, 16'd2, 3'b000},
        {3'd0, 7'b0_00_0_1_0_0, 16'd5, 16'd2, 3'b000},
        {3'd0, 7'b0_00_0_1_1_0, 16'd5, 16'd3, 3'b000},
        {3'd0, 7'b0_00_0_1_1_0, 16'd5, 16'd4, 3'b000},
        {3'd0, 7'b0_00_0_1_1_0, 16'd5, 16'd5, 3'b000},
        {3'd0, 7'b0_00_0_1_1_0, 16'd5, 16'd0, 3'b010},
        {3'd0, 7'b0_00_0_0_1_0, 16'd5, 16'd0, 3'b000},
        {3'd1, 7'b0_10_0_1_0_0, 16'd5, 16'd1, 3'b000},
        {3'd1, 7'b0_11_0_1_0_0, 16'd5, 16'd1, 3'b000},
        {3'd1, 7'b0_01_0_1_0_0, 16'd5, 16'd2, 3'b000},
        {3'd1, 7'b0_11_0_1_0_0, 16'd5, 16'd1, 3'b100},
        {3'd1, 7'b0_00_0_1_0_0, 16'd5, 16'd0, 3'b100},
        {3'd1, 7'b0_10_0_1_0_0, 16'd5, 16'd1, 3'b000},
        {3'd1, 7'b0_00_0_1_0_0, 16'd5, 16'd0, 3'b100},
        {3'd1, 7'b0_11_0_1_0_0, 16'd5, 16'd5, 3'b110},
        {3'd2, 7'b0_10_0_1_0_0, 16'd5, 16'd4, 3'b100},
        {3'd2, 7'b0_00_0_1_0_0, 16'd5, 16'd4, 3'b100},
        {3'd2, 7'b0_01_0_1_0_0, 16'd5, 16'd3, 3'b100},
        {3'd2, 7'b0_00_0_1_0_0, 16'd5, 16'd4, 3'b000},
        {3'd3, 7'b0_10_0_1_0_0, 16'd5, 16'd5, 3'b000},
        {3'd3, 7'b0_11_0_1_0_0, 16'd5, 16'd0, 3'b010},
        {3'd3, 7'b0_00_0_1_0_0, 16'd5, 16'd0, 3'b000},
        {3'd3, 7'b0_01_0_1_0_0, 16'd5, 16'd5, 3'b110},
        {3'd3, 7'b0_11_0_0_0_0, 16'd5, 16'd5, 3'b100},
        {3'd4, 7'b0_11_0_1_1_0, 16'd9, 16'd0, 3'b010},
        {3'd4, 7'b0_11_0_1_1_0, 16'd9, 16'd1, 3'b000},
        {3'd4, 7'b0_11_0_1_1_0, 16'd9, 16'd2, 3'b000},
        {3'd4, 7'b0_11_1_1_1_0, 16'd9, 16'd0, 3'b011},
        {3'd4, 7'b0_11_1_1_1_0, 16'd9, 16'd1, 3'b000},
        {3'd4, 7'b0_11_0_1_0_0, 16'd9, 16'd1, 3'b000},
        {3'd5, 7'b0_11_0_1_1_0, 16'd9, 16'd1, 3'b000},
        {3'd5, 7'b0_11_1_1_1_0, 16'd9, 16'd2, 3'b001},
        {3'd5, 7'b0_11_1_1_1_0, 16'd9, 16'd3, 3'b000},
        {3'd5, 7'b0_11_0_1_1_0, 16'd9, 16'd3, 3'b000},
        {3'd5, 7'b1_11_0_1_1_0, 16'd9, 16'd4, 3'b001},
        {3'd5, 7'b1_11_1_1_1_0, 16'd9, 16'd4, 3'b000},
        {3'd6, 7'b0_11_0_0_1_0, 16'd9, 16'd4, 3'b000},
        {3'd6, 7'b0_11_1_0_1_0, 16'd9, 16'd4, 3'b001},
        {3'd6, 7'b0_11_0_0_1_0, 16'd9, 16'd5, 3'b000},
        {3'd6, 7'b0_11_0_0_1_0, 16'd9, 16'd6, 3'b000},
        {3'd6, 7'b0_11_1_0_1_0, 16'd9, 16'd7, 3'b001},
        {3'd6, 7'b0_11_1_0_0_0, 16'd9, 16'd7, 3'b000},
        {3'd7, 7'b0_11_0_1_0_0, 16'd9, 16'd7, 3'b000},
        {3'd7, 7'b0_11_1_1_0_0, 16'd9, 16'd8, 3'b001},
        {3'd7, 7'b0_11_1_1_0_0, 16'd9, 16'd8, 3'b000},
        {3'd7, 7'b0_11_0_1_0_0, 16'd9, 16'd8, 3'b000},
        {3'd7, 7'b0_11_1_1_0_0, 16'd9, 16'd9, 3'b001},
        {3'd7, 7'b0_11_0_1_0_0, 16'd9, 16'd9, 3'b000},
        {3'd7, 7'b0_11_1_1_0_0, 16'd9, 16'd0, 3'b011},
        {3'd7, 7'b0_11_0_0_0_0, 16'd9, 16'd0, 3'b000},
        {3'd7, 7'b0_11_1_0_0_0, 16'd9, 16'd0, 3'b001},
        {3'd0, 7'b0_11_1_0_1_0, 16'd9, 16'd0, 3'b000},
        {3'd0, 7'b0_11_0_0_1_0, 16'd9, 16'd0, 3'b000},
        {3'd0, 7'b0_11_1_0_1_0, 16'd9, 16'd0, 3'b000}
    };

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0:    return "R2/R3/R4";
            3'd1:    return "R5/R8";
            3'd2:    return "R6/R8";
            3'd3:    return "R7/R8";
            3'd4:    return "R9";
            3'd5:    return "R10/R13";
            3'd6:    return "R11";
            default: return "R12/R13";
        endcase
    endfunction

    task automatic check(input string req, input logic [18:0] exp_v);
        logic [18:0] got;
        got = {count, dir_down, update_pulse, trig_pulse};
        n_chk++;
        if (got !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got count=%0d dir/upd/trg=%b expected count=%0d dir/upd/trg=%b",
                     req, got[18:3], got[2:0], exp_v[18:3], exp_v[2:0]);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic [6:0] ctl, input logic [15:0] rl);
        mode_sel   = m;
        trig_pol   = ctl[6];
        ti_a       = ctl[5];
        ti_b       = ctl[4];
        trig_in    = ctl[3];
        cnt_en     = ctl[2];
        presc_tick = ctl[1];
        sw_update  = ctl[0];
        reload_val = rl;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 19'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 19'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][44:42], VEC[i][41:35], VEC[i][34:19]);
            @(negedge clk);
            check(req_of(VEC[i][44:42]), VEC[i][18:0]);
        end

        // R1: mid-run reset clears outputs
        rst_n = 1'b0;
        drive(3'd0, 7'b0_00_0_0_0_0, 16'd3);
        @(negedge clk);
        check("R1 mid-run reset", 19'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: preload of 3 is not active before an update; count passes 3
        for (int k = 1; k <= 5; k++) begin
            drive(3'd0, 7'b0_00_0_1_1_0, 16'd3);
            @(negedge clk);
        end
        check("R4 preload inactive", {16'd5, 3'b000});

        drive(3'd0, 7'b0_00_0_1_1_1, 16'd3);
        @(negedge clk);
        check("R4 software update", {16'd0, 3'b010});

        for (int k = 1; k <= 3; k++) begin
            drive(3'd0, 7'b0_00_0_1_1_0, 16'd3);
            @(negedge clk);
        end
        check("R4 count before new wrap", {16'd3, 3'b000});
        drive(3'd0, 7'b0_00_0_1_1_0, 16'd3);
        @(negedge clk);
        check("R3/R4 wrap at new reload", {16'd0, 3'b010});

        finish_run();
    end
endmodule